// File: doc/BRIEF.md
# Pause Frame Transmit Scheduler

This block decides when an Ethernet MAC asks its transmitter to send an IEEE 802.3x pause control frame. In full-duplex operation it watches a congestion request from the receive FIFO. When that request appears, the block asks for a pause frame that carries the configured pause quanta. While the request persists, it asks again once a chosen number of slot times have passed since the transmitter accepted the previous frame. When the request goes away, it asks for a frame with zero quanta so that the link partner resumes at once. That zero-quanta frame can be suppressed by a configuration bit.

In half-duplex operation no pause frames are produced. The same enable instead drives a back-pressure output that follows the FIFO request. The block never builds frame bytes. It presents a held request with the quanta value, and the transmitter acknowledges it. A slot-time tick input (one pulse per 512 bit times) paces the resend timer.

The resend point is the pause time minus an offset chosen by a 2-bit select. When the pause time does not exceed the offset, the point clamps to one slot. Software is expected to avoid that configuration.

Top module: `pause_sched`

## Requirements
- R1: While the transmit flow-control enable is low, `frm_req` and `bp_out` stay low whatever the FIFO request does.
- R2: With the enable high and `cfg_full_dup` low, `bp_out` equals `fc_req` delayed by one clock, and no frame is requested.
- R3: With the enable high and `cfg_full_dup` high, a rise of `fc_req` raises `frm_req` one clock later, with `frm_quanta` equal to `cfg_pause_time`.
- R4: After reset `frm_req` is low. Once raised, `frm_req` and `frm_quanta` hold until a cycle with `frm_ack` high, and `frm_req` is low in the cycle after that acknowledge.
- R5: While `fc_req` stays high, the next pause request rises one clock after the N-th `slot_tick` counted from the acknowledge of the previous non-zero frame. N is `cfg_pause_time` minus an offset set by `cfg_thr_sel`: 0 gives 4, 1 gives 28, 2 gives 144, 3 gives 256. Pause time 0x100 with select 1 gives 228.
- R6: When `fc_req` falls while a pause is in force and `cfg_zq_dis` is low, a request with `frm_quanta` = 0 rises one clock later.
- R7: With `cfg_zq_dis` high, a fall of `fc_req` produces no request, and the block returns to idle, so a later rise again requests the full pause time.
- R8: An event that arrives while a request is unacknowledged is deferred. A drop of `fc_req` during a pending full-quanta request yields the zero-quanta request two clocks after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fc_en | input | 1 | Transmit flow-control enable |
| cfg_full_dup | input | 1 | 1 = full duplex (pause frames), 0 = half duplex (back pressure) |
| cfg_zq_dis | input | 1 | Suppress the zero-quanta frame on request release |
| cfg_thr_sel | input | 2 | Resend offset select (4/28/144/256 slots) |
| cfg_pause_time | input | QW | Pause quanta placed in each non-zero frame |
| slot_tick | input | 1 | One pulse per slot time |
| fc_req | input | 1 | Flow-control request from the receive FIFO |
| frm_req | output | 1 | Pause frame request to the transmitter |
| frm_quanta | output | QW | Quanta for the requested frame |
| frm_ack | input | 1 | Transmitter accepts the request |
| bp_out | output | 1 | Half-duplex back-pressure |

## Verification
The hardest state to reach is a release of the FIFO request that arrives while a full-quanta request is still waiting for its acknowledge. The transmitter model in the bench withholds `frm_ack` on purpose and drops `fc_req` during that window. It then confirms that the quanta do not change and that the zero-quanta request follows the late acknowledge. Resend timing needs hundreds of slot pulses per select value. The bench issues those pulses one at a time and counts them from the acknowledge until the request reappears.

// File: rtl/pause_sched_pkg.sv
package pause_sched_pkg;

   localparam int unsigned PS_QUANTA_W = 16;
   localparam int unsigned PS_SEL_N    = 4;

   // resend point: pause time less offset, floored at one slot
   function automatic logic [31:0] sat_thr(input logic [31:0] pt, input logic [31:0] ofs);
      return (pt > ofs) ? (pt - ofs) : 32'd1;
   endfunction

endpackage

// File: rtl/pause_thr_sel.sv
module pause_thr_sel
   import pause_sched_pkg::*;
#(
   parameter int unsigned QW      = PS_QUANTA_W,
   parameter int unsigned OFS0    = 4,
   parameter int unsigned OFS1    = 28,
   parameter int unsigned OFS2    = 144,
   parameter int unsigned OFS3    = 256,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    sel,
   input  logic [QW-1:0] pause_time,
   output logic [QW-1:0] thr
);

   localparam int unsigned OFS_TAB [PS_SEL_N] = '{OFS0, OFS1, OFS2, OFS3};

   if (QW < 2 || QW > 31) begin : g_bad_width
      $error("pause_thr_sel: QW out of range");
   end
   if (OFS3 >= (32'd1 << QW) || OFS2 >= (32'd1 << QW)) begin : g_bad_ofs
      $error("pause_thr_sel: offset does not fit the quanta width");
   end

   logic [QW-1:0] cand [PS_SEL_N];
   logic [QW-1:0] thr_c;

   for (genvar i = 0; i < PS_SEL_N; i++) begin : g_cand
      assign cand[i] = QW'(sat_thr(32'(pause_time), OFS_TAB[i]));
   end

   assign thr_c = cand[sel];

   if (REG_OUT) begin : g_reg
      logic [QW-1:0] thr_q;
      always_ff @(posedge clk) begin
         if (!rst_n) thr_q <= '1;
         else        thr_q <= thr_c;
      end
      assign thr = thr_q;
   end else begin : g_comb
      assign thr = thr_c;
   end

endmodule

// File: rtl/pause_slot_ctr.sv
module pause_slot_ctr #(
   parameter int unsigned QW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          run,
   input  logic          tick,
   output logic [QW-1:0] cnt
);

   localparam logic [QW-1:0] CNT_MAX = '1;

   always_ff @(posedge clk) begin
      if (!rst_n)                             cnt <= '0;
      else if (clr)                           cnt <= '0;
      else if (run && tick && cnt != CNT_MAX) cnt <= cnt + 1'b1;
   end

   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && run && tick && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);

   // R5
   cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0);

endmodule

// File: rtl/pause_req_ctl.sv
module pause_req_ctl #(
   parameter int unsigned QW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_fd,
   input  logic          zq_dis,
   input  logic          fc_req,
   input  logic [QW-1:0] pause_time,
   input  logic [QW-1:0] thr,
   input  logic [QW-1:0] slot_cnt,
   input  logic          ack,
   output logic          req,
   output logic [QW-1:0] quanta,
   output logic          cnt_clr,
   output logic          cnt_run
);

   logic          active_q;
   logic          armed_q;
   logic          pend_q;
   logic [QW-1:0] quanta_q;

   logic ack_hit, idle, ev_start, ev_resend, ev_stop;

   always_comb begin
      ack_hit   = pend_q & ack;
      idle      = ~pend_q;
      ev_start  = idle & fc_req & ~active_q;
      ev_resend = idle & fc_req & active_q & armed_q & (slot_cnt >= thr);
      ev_stop   = idle & ~fc_req & active_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !mode_fd) begin
         active_q <= 1'b0;
         armed_q  <= 1'b0;
         pend_q   <= 1'b0;
         quanta_q <= '0;
      end else begin
         if (ack_hit) begin
            pend_q  <= 1'b0;
            armed_q <= (quanta_q != '0);
         end
         if (ev_start || ev_resend) begin
            pend_q   <= 1'b1;
            quanta_q <= pause_time;
            active_q <= 1'b1;
            armed_q  <= 1'b0;
         end
         if (ev_stop) begin
            active_q <= 1'b0;
            armed_q  <= 1'b0;
            if (!zq_dis) begin
               pend_q   <= 1'b1;
               quanta_q <= '0;
            end
         end
      end
   end

   assign req     = pend_q;
   assign quanta  = quanta_q;
   assign cnt_clr = ack_hit;
   assign cnt_run = armed_q;

   // R1
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_fd |=> !pend_q);

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !ack && mode_fd) |=> (pend_q && $stable(quanta_q)));

   // R6
   zero_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pend_q) && quanta_q == '0) |-> $past(!fc_req && !zq_dis));

   // R5
   resend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pend_q) && $past(active_q) && quanta_q != '0) |-> $past(slot_cnt >= thr));

endmodule

// File: rtl/pause_sched.sv
module pause_sched
   import pause_sched_pkg::*;
#(
   parameter int unsigned QW      = PS_QUANTA_W,
   parameter int unsigned OFS0    = 4,
   parameter int unsigned OFS1    = 28,
   parameter int unsigned OFS2    = 144,
   parameter int unsigned OFS3    = 256,
   parameter bit          THR_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_fc_en,
   input  logic          cfg_full_dup,
   input  logic          cfg_zq_dis,
   input  logic [1:0]    cfg_thr_sel,
   input  logic [QW-1:0] cfg_pause_time,
   input  logic          slot_tick,
   input  logic          fc_req,
   output logic          frm_req,
   output logic [QW-1:0] frm_quanta,
   input  logic          frm_ack,
   output logic          bp_out
);

   logic          mode_fd;
   logic [QW-1:0] thr;
   logic [QW-1:0] slot_cnt;
   logic          cnt_clr, cnt_run;
   logic          bp_q;

   assign mode_fd = cfg_fc_en & cfg_full_dup;

   pause_thr_sel #(
      .QW(QW), .OFS0(OFS0), .OFS1(OFS1), .OFS2(OFS2), .OFS3(OFS3), .REG_OUT(THR_REG)
   ) u_thr (
      .clk(clk), .rst_n(rst_n), .sel(cfg_thr_sel), .pause_time(cfg_pause_time), .thr(thr)
   );

   pause_slot_ctr #(.QW(QW)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .run(cnt_run), .tick(slot_tick), .cnt(slot_cnt)
   );

   pause_req_ctl #(.QW(QW)) u_ctl (
      .clk(clk), .rst_n(rst_n), .mode_fd(mode_fd), .zq_dis(cfg_zq_dis), .fc_req(fc_req),
      .pause_time(cfg_pause_time), .thr(thr), .slot_cnt(slot_cnt), .ack(frm_ack),
      .req(frm_req), .quanta(frm_quanta), .cnt_clr(cnt_clr), .cnt_run(cnt_run)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) bp_q <= 1'b0;
      else        bp_q <= cfg_fc_en & ~cfg_full_dup & fc_req;
   end
   assign bp_out = bp_q;

   // R2
   bp_fd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_full_dup |=> !bp_out);

   // R1
   bp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_fc_en |=> !bp_out);

endmodule

// File: tb/pause_sched_test.sv
module pause_sched_test;

   localparam int QW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_fc_en = 1'b0;
   logic          cfg_full_dup = 1'b0;
   logic          cfg_zq_dis = 1'b0;
   logic [1:0]    cfg_thr_sel = 2'd0;
   logic [QW-1:0] cfg_pause_time = '0;
   logic          slot_tick = 1'b0;
   logic          fc_req = 1'b0;
   logic          frm_ack = 1'b0;
   logic          frm_req;
   logic [QW-1:0] frm_quanta;
   logic          bp_out;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   pause_sched uut (
      .clk(clk), .rst_n(rst_n), .cfg_fc_en(cfg_fc_en), .cfg_full_dup(cfg_full_dup),
      .cfg_zq_dis(cfg_zq_dis), .cfg_thr_sel(cfg_thr_sel), .cfg_pause_time(cfg_pause_time),
      .slot_tick(slot_tick), .fc_req(fc_req), .frm_req(frm_req), .frm_quanta(frm_quanta),
      .frm_ack(frm_ack), .bp_out(bp_out)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic give_ack(input string tag);
      frm_ack = 1'b1;
      @(negedge clk);
      frm_ack = 1'b0;
      chk(frm_req == 1'b0, tag, frm_req, 0);
   endtask

   task automatic t_reset;
      cyc(1);
      chk(frm_req == 1'b0, "R4 reset req", frm_req, 0);
      chk(bp_out == 1'b0, "R4 reset bp", bp_out, 0);
   endtask

   task automatic t_off;
      bit seen = 1'b0;
      cfg_fc_en = 1'b0; cfg_full_dup = 1'b1; cfg_pause_time = 16'd50;
      fc_req = 1'b1;
      for (int i = 0; i < 30; i++) begin
         slot_tick = 1'b1; @(negedge clk); slot_tick = 1'b0; @(negedge clk);
         if (frm_req || bp_out) seen = 1'b1;
      end
      chk(!seen, "R1 enable low quiet", seen, 0);
      fc_req = 1'b0; cyc(2);
   endtask

   task automatic t_half;
      cfg_fc_en = 1'b1; cfg_full_dup = 1'b0;
      fc_req = 1'b1; @(negedge clk);
      chk(bp_out == 1'b1, "R2 bp follows high", bp_out, 1);
      chk(frm_req == 1'b0, "R2 no frame half", frm_req, 0);
      cyc(3);
      fc_req = 1'b0; @(negedge clk);
      chk(bp_out == 1'b0, "R2 bp follows low", bp_out, 0);
      cfg_full_dup = 1'b1; cyc(2);
   endtask

   task automatic t_resend(input logic [1:0] sel, input int pt, input int exp);
      int n = 0;
      cfg_fc_en = 1'b1; cfg_full_dup = 1'b1; cfg_zq_dis = 1'b0;
      cfg_thr_sel = sel; cfg_pause_time = QW'(pt);
      cyc(2);
      fc_req = 1'b1; @(negedge clk);
      chk(frm_req == 1'b1, "R3 first request", frm_req, 1);
      chk(frm_quanta == QW'(pt), "R3 first quanta", frm_quanta, pt);
      cyc(3);
      chk(frm_req == 1'b1 && frm_quanta == QW'(pt), "R4 held without ack", frm_quanta, pt);
      give_ack("R4 cleared after ack");
      for (int i = 1; i <= exp + 5; i++) begin
         slot_tick = 1'b1; @(negedge clk); slot_tick = 1'b0; @(negedge clk);
         if (frm_req) begin n = i; break; end
      end
      chk(n == exp, "R5 resend slot count", n, exp);
      chk(frm_quanta == QW'(pt), "R5 resend quanta", frm_quanta, pt);
      give_ack("R4 resend acked");
      fc_req = 1'b0; @(negedge clk);
      chk(frm_req == 1'b1 && frm_quanta == '0, "R6 zero quanta on release", frm_quanta, 0);
      give_ack("R6 zero acked");
      cyc(2);
   endtask

   task automatic t_zq_dis;
      bit seen = 1'b0;
      cfg_zq_dis = 1'b1; cfg_pause_time = 16'd77; cfg_thr_sel = 2'd0;
      fc_req = 1'b1; @(negedge clk);
      chk(frm_req == 1'b1, "R7 request before release", frm_req, 1);
      give_ack("R7 ack");
      fc_req = 1'b0;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (frm_req) seen = 1'b1;
      end
      chk(!seen, "R7 no zero frame", seen, 0);
      fc_req = 1'b1; @(negedge clk);
      chk(frm_req == 1'b1 && frm_quanta == 16'd77, "R7 back to idle", frm_quanta, 77);
      give_ack("R7 ack again");
      cfg_zq_dis = 1'b0;
      fc_req = 1'b0; @(negedge clk);
      chk(frm_req == 1'b1 && frm_quanta == '0, "R6 zero after enable", frm_quanta, 0);
      give_ack("R6 ack");
      cyc(2);
   endtask

   task automatic t_holdoff;
      cfg_pause_time = 16'd90;
      fc_req = 1'b1; @(negedge clk);
      fc_req = 1'b0;
      cyc(4);
      chk(frm_req == 1'b1 && frm_quanta == 16'd90, "R8 pending kept", frm_quanta, 90);
      give_ack("R8 low after ack");
      @(negedge clk);
      chk(frm_req == 1'b1 && frm_quanta == '0, "R8 deferred zero", frm_quanta, 0);
      give_ack("R8 zero acked");
      cyc(2);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      t_reset();
      t_off();
      t_half();
      t_resend(2'd0, 300, 296);
      t_resend(2'd1, 300, 272);
      t_resend(2'd2, 300, 156);
      t_resend(2'd3, 300, 44);
      t_resend(2'd1, 256, 228);
      t_zq_dis();
      t_holdoff();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule